// File: doc/BRIEF.md
# Event Counter with Shared Divider

This block is an 8-bit event counter whose source is either the instruction-cycle tick or edges on an external count pin. A single 8-bit prescaler sits alongside it and serves one of two users at a time: the event counter or the watchdog tick path. When the prescaler belongs to the counter, the watchdog base tick goes straight through as a time-out request. When the prescaler belongs to the watchdog, the counter advances once on every selected source event.

A 6-bit mode word controls the block. Bit 5 selects the source (0 = cycle tick, 1 = external pin). Bit 4 selects the pin edge (0 = rising, 1 = falling). Bit 3 selects the prescaler owner (0 = counter, 1 = watchdog). Bits 2:0 hold the ratio code `c`. The same code divides by 2^(c+1) for the counter and by 2^c for the watchdog.

Software writes the counter and the mode word through strobed write ports and reads the counter value continuously. Two one-cycle pulses are output: one when the counter wraps, and one as a watchdog reset request.

Top module: `tmr_rtc_top`

## Requirements
- R1: After reset the mode word is 6'b111111 (pin source, falling edge, prescaler on watchdog, code 7), the counter reads 00h, and both pulse outputs are low.
- R2: With mode bit 5 = 0 the counter source is `cyc_tick` and pin edges are ignored. With bit 5 = 1 the source is pin edges and `cyc_tick` is ignored.
- R3: With the pin selected, mode bit 4 = 0 counts low-to-high transitions of `ext_pin` and bit 4 = 1 counts high-to-low transitions, after a two-flop synchronizer.
- R4: With mode bit 3 = 1 the counter advances by one on every source event. With bit 3 = 0 every watchdog base tick gives a time-out.
- R5: With mode bit 3 = 0 and code c in bits 2:0, the counter advances once per 2^(c+1) source events (1:2 to 1:256).
- R6: With mode bit 3 = 1 and code c, one time-out is issued per 2^c watchdog base ticks (1:1 to 1:128).
- R7: A counter write loads `cnt_wr_data` at the next clock edge and takes priority over an increment in the same cycle. Without a write or event the value holds.
- R8: A counter write or a watchdog clear resets the prescaler count. A watchdog clear also suppresses a time-out from a base tick in the same cycle.
- R9: `cnt_ovf` is a one-cycle pulse, high in the cycle the counter first reads 00h after an increment from FFh. Loading 00h by a write gives no pulse.
- R10: `wdt_timeout` is a one-cycle pulse issued in the cycle after the qualifying watchdog base tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle tick, one clock wide |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_base_tick | input | 1 | Watchdog base period tick, one clock wide |
| wdt_clear | input | 1 | Watchdog clear strobe |
| cnt_wr_en | input | 1 | Counter write strobe |
| cnt_wr_data | input | 8 | Counter write value |
| mode_wr_en | input | 1 | Mode word write strobe |
| mode_wr_data | input | 6 | Mode word write value |
| cnt_value | output | 8 | Current counter value |
| cnt_ovf | output | 1 | Counter wrap pulse |
| wdt_timeout | output | 1 | Watchdog reset request pulse |

## Verification
The hardest state to reach from the ports is a partly filled prescaler being cleared, because the count is hidden and only shows later as a shifted output event. The bench loads a known number of events short of a full ratio, then issues a counter write or a watchdog clear. It then counts how many further events are needed before the next counter step or time-out. The widest ratios, 1:256 on the counter and 1:128 on the watchdog, are driven with several hundred events each, so the full prescaler width has to wrap.

// File: rtl/tmr_pkg.sv
// Package: shared types and constants for the event counter with shared divider.
// Assumes the mode word layout is fixed at six bits, ordered MSB first.
package tmr_pkg;

    localparam int MODE_W = 6;
    localparam int CODE_W = 3;

    // Mode word: bit 5 source, bit 4 edge, bit 3 owner, bits 2:0 ratio code
    typedef struct packed {
        logic              src_ext;    // 1: pin edges, 0: cycle tick
        logic              edge_fall;  // 1: falling edge, 0: rising edge
        logic              ps_to_wdt;  // 1: prescaler on watchdog
        logic [CODE_W-1:0] ratio;      // divide code
    } tmr_mode_t;

    localparam tmr_mode_t MODE_RST = '{src_ext: 1'b1, edge_fall: 1'b1,
                                       ps_to_wdt: 1'b1, ratio: 3'b111};

endpackage

// File: rtl/tmr_src_select.sv
// Module: synchronizes the external pin, detects the chosen edge and
// selects between pin edges and the cycle tick as the counter source.
// Assumes SYNC_STAGES >= 2 and that cyc_tick is one clock wide.
module tmr_src_select #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic cyc_tick,
    input  logic src_ext,
    input  logic edge_fall,
    output logic src_event
);

    localparam int MSB = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   rise;
    logic                   fall;
    logic                   pin_event;

    // Synchronizer chain plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
            last_q <= sync_q[MSB];
        end
    end

    // Edge decode and source selection
    always_comb begin
        rise      = sync_q[MSB] & ~last_q;
        fall      = ~sync_q[MSB] & last_q;
        pin_event = edge_fall ? fall : rise;
        src_event = src_ext ? pin_event : cyc_tick;
    end

    // A pin-sourced event needs a level change across the history stage
    p_pin_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ext && src_event) |-> (sync_q[MSB] != last_q));

endmodule

// File: rtl/tmr_prescaler.sv
// Module: shared power-of-two divider. It counts input events and passes
// one event through per full ratio. The ratio for a code is one step
// larger when the counter owns the divider than when the watchdog does.
// Assumes clr has priority over counting.
module tmr_prescaler #(
    parameter int PS_W   = 8,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ev_in,
    input  logic              to_wdt,
    input  logic [CODE_W-1:0] ratio,
    output logic              ev_out
);

    localparam int SH_W = CODE_W + 1;

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] mask;
    logic [SH_W-1:0] shift;

    // Division mask: low bits that must all be one before an event passes
    always_comb begin
        shift  = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + SH_W'(1));
        mask   = ~({PS_W{1'b1}} << shift);
        ev_out = ev_in && !clr && ((ps_cnt & mask) == mask);
    end

    // Event count, cleared on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_cnt <= '0;
        end else if (clr) begin
            ps_cnt <= '0;
        end else if (ev_in) begin
            ps_cnt <= ps_cnt + PS_W'(1);
        end
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ps_cnt == '0));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_in && !clr) |=> (ps_cnt == $past(ps_cnt) + PS_W'(1)));

endmodule

// File: rtl/tmr_counter.sv
// Module: loadable event counter with a registered wrap pulse.
// Assumes a write has priority over an increment in the same cycle.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);

    // Count register and wrap flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (wr_en) begin
                cnt_q <= wr_data;
            end else if (inc) begin
                cnt_q <= cnt_q + CNT_W'(1);
                ovf_q <= &cnt_q;
            end
        end
    end

    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc) |=> $stable(cnt_q));

    p_ovf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (cnt_q == '0));

    p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |=> !ovf_q);

endmodule

// File: rtl/tmr_rtc_top.sv
// Module: event counter with one prescaler shared with the watchdog path.
// Holds the mode word, routes the prescaler to its owner and registers
// the watchdog time-out pulse. Assumes all tick inputs are one clock wide.
module tmr_rtc_top #(
    parameter int CNT_W       = 8,
    parameter int PS_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cyc_tick,
    input  logic                      ext_pin,
    input  logic                      wdt_base_tick,
    input  logic                      wdt_clear,
    input  logic                      cnt_wr_en,
    input  logic [CNT_W-1:0]          cnt_wr_data,
    input  logic                      mode_wr_en,
    input  logic [tmr_pkg::MODE_W-1:0] mode_wr_data,
    output logic [CNT_W-1:0]          cnt_value,
    output logic                      cnt_ovf,
    output logic                      wdt_timeout
);

    import tmr_pkg::*;

    tmr_mode_t mode_q;
    logic      src_event;
    logic      ps_in;
    logic      ps_out;
    logic      ps_clr;
    logic      cnt_inc;
    logic      wdt_event;

    // Mode word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else if (mode_wr_en) begin
            mode_q <= tmr_mode_t'(mode_wr_data);
        end
    end

    tmr_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_pin  (ext_pin),
        .cyc_tick (cyc_tick),
        .src_ext  (mode_q.src_ext),
        .edge_fall(mode_q.edge_fall),
        .src_event(src_event)
    );

    // Route the prescaler between counter and watchdog paths
    always_comb begin
        ps_clr    = cnt_wr_en | wdt_clear;
        ps_in     = mode_q.ps_to_wdt ? wdt_base_tick : src_event;
        cnt_inc   = mode_q.ps_to_wdt ? src_event : ps_out;
        wdt_event = (mode_q.ps_to_wdt ? ps_out : wdt_base_tick) & ~wdt_clear;
    end

    tmr_prescaler #(.PS_W(PS_W), .CODE_W(CODE_W)) u_ps (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ps_clr),
        .ev_in (ps_in),
        .to_wdt(mode_q.ps_to_wdt),
        .ratio (mode_q.ratio),
        .ev_out(ps_out)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (cnt_inc),
        .wr_en  (cnt_wr_en),
        .wr_data(cnt_wr_data),
        .cnt_q  (cnt_value),
        .ovf_q  (cnt_ovf)
    );

    // Registered watchdog time-out request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_timeout <= 1'b0;
        end else begin
            wdt_timeout <= wdt_event;
        end
    end

    p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> (mode_q == $past(mode_wr_data)));

    p_timeout_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_timeout |-> ($past(wdt_base_tick) && !$past(wdt_clear)));

    p_clear_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clear |=> !wdt_timeout);

endmodule

// File: tb/tmr_rtc_top_tb_top.sv
`timescale 1ns/1ps
module tmr_rtc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wdt_base_tick = 1'b0;
    logic       wdt_clear = 1'b0;
    logic       cnt_wr_en = 1'b0;
    logic [7:0] cnt_wr_data = 8'h00;
    logic       mode_wr_en = 1'b0;
    logic [5:0] mode_wr_data = 6'h00;
    logic [7:0] cnt_value;
    logic       cnt_ovf;
    logic       wdt_timeout;

    int checks = 0;
    int errors = 0;
    int ovf_total = 0;
    int to_total = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    tmr_rtc_top dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wdt_base_tick(wdt_base_tick), .wdt_clear(wdt_clear),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .cnt_value(cnt_value), .cnt_ovf(cnt_ovf), .wdt_timeout(wdt_timeout)
    );

    // Pulse monitors, sampled away from the active edge
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && cnt_ovf) ovf_total <= ovf_total + 1;
        if (rst_n && wdt_timeout) to_total <= to_total + 1;
    end

    typedef struct packed {
        logic [5:0]  mode;
        logic [7:0]  start;
        logic [15:0] n_cyc;
        logic [15:0] n_ext;
        logic [15:0] n_wdt;
        logic [7:0]  exp_cnt;
        logic [7:0]  exp_ovf;
        logic [7:0]  exp_to;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 8'h00, 16'd10,  16'd3, 16'd3,   8'h05, 8'd0, 8'd3}, // R2 R4 R5 internal 1:2
        '{6'h08, 8'hFE, 16'd5,   16'd0, 16'd4,   8'h03, 8'd1, 8'd4}, // R4 R6 R9 undivided
        '{6'h0B, 8'h10, 16'd3,   16'd0, 16'd17,  8'h13, 8'd0, 8'd2}, // R6 wdt 1:8
        '{6'h03, 8'hF0, 16'd40,  16'd0, 16'd2,   8'hF2, 8'd0, 8'd2}, // R5 1:16
        '{6'h28, 8'h00, 16'd4,   16'd6, 16'd0,   8'h06, 8'd0, 8'd0}, // R2 R3 rising
        '{6'h38, 8'hFF, 16'd0,   16'd3, 16'd0,   8'h02, 8'd1, 8'd0}, // R3 R9 falling
        '{6'h20, 8'h00, 16'd0,   16'd7, 16'd0,   8'h03, 8'd0, 8'd0}, // R3 R5 pin 1:2
        '{6'h07, 8'h7F, 16'd600, 16'd0, 16'd0,   8'h81, 8'd0, 8'd0}, // R5 1:256
        '{6'h0F, 8'h00, 16'd2,   16'd0, 16'd300, 8'h02, 8'd0, 8'd2}  // R6 1:128
    };

    task automatic chk(input string req, input int act, input int exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [5:0] m);
        mode_wr_en = 1'b1; mode_wr_data = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] d);
        cnt_wr_en = 1'b1; cnt_wr_data = d;
        @(negedge clk);
        cnt_wr_en = 1'b0;
    endtask

    task automatic cyc_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1; @(negedge clk);
            cyc_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic wdt_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            wdt_base_tick = 1'b1; @(negedge clk);
            wdt_base_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = 1'b1; idle(3);
            ext_pin = 1'b0; idle(3);
        end
    endtask

    // Watchdog on the run itself
    initial begin
        while (cycles < 150000) @(negedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=done", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ob;
        int tb;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cnt_value", int'(cnt_value), 0);
        chk("R1 cnt_ovf", int'(cnt_ovf), 0);
        chk("R1 wdt_timeout", int'(wdt_timeout), 0);
        // R1: reset mode gives watchdog 1:128
        tb = to_total;
        wdt_pulses(127); idle(2);
        chk("R1 wdt 127 ticks", to_total - tb, 0);
        wdt_pulses(1); idle(2);
        chk("R1 wdt 128th tick", to_total - tb, 1);
        // R1: reset mode counts falling pin edges undivided, ignores cycle tick
        cyc_pulses(2);
        ext_pulses(1); idle(5);
        chk("R1 pin falling undivided", int'(cnt_value), 1);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr_mode(VECS[v].mode);
            wr_cnt(VECS[v].start);
            ob = ovf_total; tb = to_total;
            cyc_pulses(int'(VECS[v].n_cyc));
            ext_pulses(int'(VECS[v].n_ext));
            wdt_pulses(int'(VECS[v].n_wdt));
            idle(5);
            chk($sformatf("R2-vec%0d count", v), int'(cnt_value), int'(VECS[v].exp_cnt));
            chk($sformatf("R9 vec%0d ovf", v), ovf_total - ob, int'(VECS[v].exp_ovf));
            chk($sformatf("R6 vec%0d timeouts", v), to_total - tb, int'(VECS[v].exp_to));
        end

        // R7: write wins over same-cycle increment
        wr_mode(6'h08);
        cyc_tick = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 8'h55;
        @(negedge clk);
        cyc_tick = 1'b0; cnt_wr_en = 1'b0;
        chk("R7 write priority", int'(cnt_value), 8'h55);
        cyc_pulses(1);
        chk("R7 increment after write", int'(cnt_value), 8'h56);

        // R9: loading 00h by write gives no wrap pulse
        ob = ovf_total;
        wr_cnt(8'hFF); wr_cnt(8'h00); idle(2);
        chk("R9 write no ovf", ovf_total - ob, 0);

        // R10: timeout one cycle after tick, one cycle wide
        wdt_base_tick = 1'b1; @(negedge clk);
        wdt_base_tick = 1'b0;
        chk("R10 timeout high", int'(wdt_timeout), 1);
        @(negedge clk);
        chk("R10 timeout low", int'(wdt_timeout), 0);

        // R8: clear in same cycle as tick suppresses timeout
        tb = to_total;
        wdt_base_tick = 1'b1; wdt_clear = 1'b1; @(negedge clk);
        wdt_base_tick = 1'b0; wdt_clear = 1'b0; idle(2);
        chk("R8 clear suppresses", to_total - tb, 0);

        // R8: watchdog clear restarts a 1:8 watchdog divider
        wr_mode(6'h0B); wr_cnt(8'h00);
        tb = to_total;
        wdt_pulses(5);
        wdt_clear = 1'b1; @(negedge clk); wdt_clear = 1'b0;
        wdt_pulses(7); idle(2);
        chk("R8 wdt clear restart 7", to_total - tb, 0);
        wdt_pulses(1); idle(2);
        chk("R8 wdt clear restart 8", to_total - tb, 1);

        // R8: counter write restarts a 1:4 counter divider
        wr_mode(6'h01); wr_cnt(8'h00);
        cyc_pulses(3);
        wr_cnt(8'h20);
        cyc_pulses(3);
        chk("R8 cnt write restart 3", int'(cnt_value), 8'h20);
        cyc_pulses(1);
        chk("R8 cnt write restart 4", int'(cnt_value), 8'h21);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule